// File: doc/BRIEF.md
# Non-secure control field masking unit

This block works out the values that software and hardware actually see for two lower-privilege control registers. The first is the coprocessor access register, which holds a trace-disable bit, a SIMD-disable bit and two access fields for the floating-point coprocessors. The second is the hypervisor trap register, which holds a trace trap, a SIMD trap and two coprocessor trap bits. Three bits from a higher-privilege access-control register drive the block: trace off, SIMD off, and Non-secure floating-point enable. Together with the current security state, these bits decide whether each lower field passes its stored value through or is forced to a fixed value.

A forced field also loses its write enable, so the register file around the block keeps its stored content. That makes the field read-fixed and write-ignored. Overrides on the coprocessor access register apply only in the Non-secure state. Overrides on the hypervisor trap register apply in either state. The block is purely combinational, and register storage and access decoding sit outside it. When a control bit is cleared, the stored setting shows through again at once.

Top module: `ns_ctrl_mask`

## Requirements
- R1: With trace off set and the Non-secure state (nonsecure_i = 1), the coprocessor trace-disable output reads 1 and its write enable is 0.
- R2: With trace off set, the hypervisor trace-trap output reads 1 and its write enable is 0, in either security state.
- R3: With SIMD off set and the Non-secure state, the coprocessor SIMD-disable output reads 1 and its write enable is 0.
- R4: With SIMD off set, the hypervisor SIMD-trap output reads 1 and its write enable is 0, in either security state.
- R5: With the floating-point enable at 0 and the Non-secure state, both coprocessor access fields read 2'b00 and both write enables are 0.
- R6: With the floating-point enable at 0, both hypervisor coprocessor trap outputs read 1 and both write enables are 0, in either security state.
- R7: A field whose override condition is false outputs its stored value unchanged with write enable 1. This includes every coprocessor field in the Secure state (nonsecure_i = 0).
- R8: With the floating-point enable at 1, each coprocessor access field passes any stored 2-bit value through unchanged.
- R9: Overrides leave stored inputs untouched. After a control bit returns to 0, the outputs show the stored value again in the same cycle.
- R10: Each write enable is the inverse of that field's override condition and changes in the same cycle as its inputs. A field whose write enable is 1 never outputs a value that differs from its stored input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| trc_off_i | input | 1 | Access-control trace-disable bit |
| simd_off_i | input | 1 | Access-control SIMD-disable bit |
| fp_ns_en_i | input | 1 | Access-control Non-secure floating-point enable |
| nonsecure_i | input | 1 | 1 when the processor is in the Non-secure state |
| cop_trc_dis_i | input | 1 | Stored coprocessor trace-disable bit |
| cop_simd_dis_i | input | 1 | Stored coprocessor SIMD-disable bit |
| cop_acc11_i | input | ACC_W | Stored access field for coprocessor 11 |
| cop_acc10_i | input | ACC_W | Stored access field for coprocessor 10 |
| hyp_trc_trap_i | input | 1 | Stored hypervisor trace-trap bit |
| hyp_simd_trap_i | input | 1 | Stored hypervisor SIMD-trap bit |
| hyp_trap11_i | input | 1 | Stored hypervisor coprocessor 11 trap bit |
| hyp_trap10_i | input | 1 | Stored hypervisor coprocessor 10 trap bit |
| cop_trc_dis_o | output | 1 | Effective coprocessor trace-disable |
| cop_simd_dis_o | output | 1 | Effective coprocessor SIMD-disable |
| cop_acc11_o | output | ACC_W | Effective coprocessor 11 access field |
| cop_acc10_o | output | ACC_W | Effective coprocessor 10 access field |
| cop_wen_o | output | 4 | Coprocessor write enables {trace, SIMD, acc11, acc10} |
| hyp_trc_trap_o | output | 1 | Effective hypervisor trace trap |
| hyp_simd_trap_o | output | 1 | Effective hypervisor SIMD trap |
| hyp_trap11_o | output | 1 | Effective hypervisor coprocessor 11 trap |
| hyp_trap10_o | output | 1 | Effective hypervisor coprocessor 10 trap |
| hyp_wen_o | output | 4 | Hypervisor write enables {trace, SIMD, trap11, trap10} |

## Verification
The bench first walks a table of hand-picked patterns. Each pattern sets one control bit at a time in each security state, so it can tell a state-gated coprocessor override apart from the ungated hypervisor override. Stored fields are set to values opposite to the forced ones, so that a forced output cannot match by accident. An exhaustive sweep over all control, state and stored combinations then catches any cross-coupling between fields. The sweep also catches any missing pass-through of the 2-bit access values. Directed steps hold the stored values while a control bit is set and then cleared, which shows the original settings coming back.

// File: rtl/nsmask_pkg.sv
package nsmask_pkg;

    // One override condition per control group
    typedef struct packed {
        logic trc;
        logic simd;
        logic fp;
    } force_set_t;

    localparam int unsigned FIELD_CNT = 4;

endpackage

// File: rtl/ns_force_decode.sv
module ns_force_decode
    import nsmask_pkg::*;
(
    input  logic       trc_off_i,
    input  logic       simd_off_i,
    input  logic       fp_ns_en_i,
    input  logic       nonsecure_i,
    output force_set_t cop_force_o,
    output force_set_t hyp_force_o
);

    force_set_t hyp_d;
    force_set_t cop_d;

    always_comb begin
        // Hypervisor trap overrides ignore the security state
        hyp_d.trc  = trc_off_i;
        hyp_d.simd = simd_off_i;
        hyp_d.fp   = ~fp_ns_en_i;
        // Coprocessor overrides only take effect when Non-secure
        cop_d.trc  = hyp_d.trc  & nonsecure_i;
        cop_d.simd = hyp_d.simd & nonsecure_i;
        cop_d.fp   = hyp_d.fp   & nonsecure_i;
    end

    assign cop_force_o = cop_d;
    assign hyp_force_o = hyp_d;

endmodule

// File: rtl/field_override.sv
module field_override #(
    parameter int unsigned     W         = 1,
    parameter logic [W-1:0]    FORCE_VAL = '0
) (
    input  logic         force_i,
    input  logic [W-1:0] stored_i,
    output logic [W-1:0] eff_o,
    output logic         wen_o
);

    always_comb begin
        eff_o = force_i ? FORCE_VAL : stored_i;
        wen_o = ~force_i;
    end

endmodule

// File: rtl/ns_ctrl_mask.sv
module ns_ctrl_mask
    import nsmask_pkg::*;
#(
    parameter int unsigned ACC_W = 2
) (
    input  logic             trc_off_i,
    input  logic             simd_off_i,
    input  logic             fp_ns_en_i,
    input  logic             nonsecure_i,
    input  logic             cop_trc_dis_i,
    input  logic             cop_simd_dis_i,
    input  logic [ACC_W-1:0] cop_acc11_i,
    input  logic [ACC_W-1:0] cop_acc10_i,
    input  logic             hyp_trc_trap_i,
    input  logic             hyp_simd_trap_i,
    input  logic             hyp_trap11_i,
    input  logic             hyp_trap10_i,
    output logic             cop_trc_dis_o,
    output logic             cop_simd_dis_o,
    output logic [ACC_W-1:0] cop_acc11_o,
    output logic [ACC_W-1:0] cop_acc10_o,
    output logic [3:0]       cop_wen_o,
    output logic             hyp_trc_trap_o,
    output logic             hyp_simd_trap_o,
    output logic             hyp_trap11_o,
    output logic             hyp_trap10_o,
    output logic [3:0]       hyp_wen_o
);

    localparam logic [ACC_W-1:0] ACC_DENY = '0;

    force_set_t cop_force;
    force_set_t hyp_force;

    ns_force_decode u_decode (
        .trc_off_i   (trc_off_i),
        .simd_off_i  (simd_off_i),
        .fp_ns_en_i  (fp_ns_en_i),
        .nonsecure_i (nonsecure_i),
        .cop_force_o (cop_force),
        .hyp_force_o (hyp_force)
    );

    // Coprocessor access register fields
    field_override #(.W(1), .FORCE_VAL(1'b1)) u_cop_trc (
        .force_i (cop_force.trc), .stored_i (cop_trc_dis_i),
        .eff_o (cop_trc_dis_o), .wen_o (cop_wen_o[3])
    );
    field_override #(.W(1), .FORCE_VAL(1'b1)) u_cop_simd (
        .force_i (cop_force.simd), .stored_i (cop_simd_dis_i),
        .eff_o (cop_simd_dis_o), .wen_o (cop_wen_o[2])
    );
    field_override #(.W(ACC_W), .FORCE_VAL(ACC_DENY)) u_cop_acc11 (
        .force_i (cop_force.fp), .stored_i (cop_acc11_i),
        .eff_o (cop_acc11_o), .wen_o (cop_wen_o[1])
    );
    field_override #(.W(ACC_W), .FORCE_VAL(ACC_DENY)) u_cop_acc10 (
        .force_i (cop_force.fp), .stored_i (cop_acc10_i),
        .eff_o (cop_acc10_o), .wen_o (cop_wen_o[0])
    );

    // Hypervisor trap register fields: all single bits forced to one
    logic [FIELD_CNT-1:0] hyp_stored;
    logic [FIELD_CNT-1:0] hyp_frc;
    logic [FIELD_CNT-1:0] hyp_eff;

    assign hyp_stored = {hyp_trc_trap_i, hyp_simd_trap_i, hyp_trap11_i, hyp_trap10_i};
    assign hyp_frc    = {hyp_force.trc, hyp_force.simd, hyp_force.fp, hyp_force.fp};

    for (genvar i = 0; i < FIELD_CNT; i++) begin : g_hyp
        field_override #(.W(1), .FORCE_VAL(1'b1)) u_hyp (
            .force_i  (hyp_frc[i]),
            .stored_i (hyp_stored[i]),
            .eff_o    (hyp_eff[i]),
            .wen_o    (hyp_wen_o[i])
        );
    end

    assign {hyp_trc_trap_o, hyp_simd_trap_o, hyp_trap11_o, hyp_trap10_o} = hyp_eff;

    // Checks relating ports across the submodules
    always_comb begin
        if (nonsecure_i && trc_off_i)
            p_cop_trc_forced_r1: assert (cop_trc_dis_o && !cop_wen_o[3])
                else $error("R1 cop trace not forced");
        if (trc_off_i)
            p_hyp_trc_forced_r2: assert (hyp_trc_trap_o && !hyp_wen_o[3])
                else $error("R2 hyp trace not forced");
        if (nonsecure_i && simd_off_i)
            p_cop_simd_forced_r3: assert (cop_simd_dis_o && !cop_wen_o[2])
                else $error("R3 cop simd not forced");
        if (simd_off_i)
            p_hyp_simd_forced_r4: assert (hyp_simd_trap_o && !hyp_wen_o[2])
                else $error("R4 hyp simd not forced");
        if (nonsecure_i && !fp_ns_en_i)
            p_cop_acc_deny_r5: assert (cop_acc11_o == '0 && cop_acc10_o == '0
                                       && cop_wen_o[1:0] == 2'b00)
                else $error("R5 cop access not denied");
        if (!fp_ns_en_i)
            p_hyp_cp_trap_r6: assert (hyp_trap11_o && hyp_trap10_o && hyp_wen_o[1:0] == 2'b00)
                else $error("R6 hyp cp traps not forced");
        if (!nonsecure_i)
            p_secure_pass_r7: assert (cop_wen_o == 4'hF && cop_trc_dis_o == cop_trc_dis_i
                                      && cop_simd_dis_o == cop_simd_dis_i
                                      && cop_acc11_o == cop_acc11_i && cop_acc10_o == cop_acc10_i)
                else $error("R7 secure coprocessor fields altered");
        if (fp_ns_en_i)
            p_acc_pass_r8: assert (cop_acc11_o == cop_acc11_i && cop_acc10_o == cop_acc10_i)
                else $error("R8 access field not passed");
        p_wen_consistent_r10: assert (!(hyp_wen_o[3] && hyp_trc_trap_o != hyp_trc_trap_i)
                                      && !(hyp_wen_o[0] && hyp_trap10_o != hyp_trap10_i)
                                      && !(cop_wen_o[1] && cop_acc11_o != cop_acc11_i))
            else $error("R10 writable field differs from stored");
    end

endmodule

// File: tb/ns_ctrl_mask_bench.sv
module ns_ctrl_mask_bench;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 12;

    // {trc_off, simd_off, fp_en, ns, ctrc, csimd, acc11[1:0], acc10[1:0], htrc, hsimd, t11, t10}
    localparam logic [13:0] VEC [NVEC] = '{
        14'b0010_00_00_00_0000, // R7 idle, Secure
        14'b0011_00_10_01_0000, // R7/R8 idle, Non-secure, access passes
        14'b1011_00_11_11_0000, // R1 R2 trace off, Non-secure
        14'b1010_00_11_11_0000, // R2 trace off, Secure: cop passes
        14'b0111_00_01_10_0000, // R3 R4 SIMD off, Non-secure
        14'b0110_00_01_10_0000, // R4 SIMD off, Secure
        14'b0001_11_11_11_0000, // R5 R6 fp disabled, Non-secure
        14'b0000_11_11_11_0000, // R6 fp disabled, Secure
        14'b1101_00_01_11_0000, // R1..R6 all overrides, Non-secure
        14'b1100_00_01_11_0000, // R2 R4 R6 all overrides, Secure
        14'b0011_11_11_10_1111, // R8 stored values kept with fp enabled
        14'b1111_01_01_01_0101  // mixed stored bits, trace and SIMD off
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic       trc_off, simd_off, fp_en, ns;
    logic       ctrc, csimd, htrc, hsimd, t11, t10;
    logic [1:0] a11, a10;
    logic       o_ctrc, o_csimd, o_htrc, o_hsimd, o_t11, o_t10;
    logic [1:0] o_a11, o_a10;
    logic [3:0] o_cwen, o_hwen;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    ns_ctrl_mask #(.ACC_W(2)) u_ns_ctrl_mask (
        .trc_off_i (trc_off), .simd_off_i (simd_off), .fp_ns_en_i (fp_en), .nonsecure_i (ns),
        .cop_trc_dis_i (ctrc), .cop_simd_dis_i (csimd), .cop_acc11_i (a11), .cop_acc10_i (a10),
        .hyp_trc_trap_i (htrc), .hyp_simd_trap_i (hsimd), .hyp_trap11_i (t11), .hyp_trap10_i (t10),
        .cop_trc_dis_o (o_ctrc), .cop_simd_dis_o (o_csimd), .cop_acc11_o (o_a11), .cop_acc10_o (o_a10),
        .cop_wen_o (o_cwen), .hyp_trc_trap_o (o_htrc), .hyp_simd_trap_o (o_hsimd),
        .hyp_trap11_o (o_t11), .hyp_trap10_o (o_t10), .hyp_wen_o (o_hwen)
    );

    task automatic drive(input logic [13:0] v);
        @(posedge clk);
        {trc_off, simd_off, fp_en, ns, ctrc, csimd, a11, a10, htrc, hsimd, t11, t10} = v;
    endtask

    // Expected outputs from the requirements: {cop eff 6, cop wen 4, hyp eff 4, hyp wen 4}
    function automatic logic [17:0] expect_of(input logic [13:0] v);
        logic tf, sf, fe, n, ct, cs, ht, hs, p11, p10;
        logic [1:0] x11, x10;
        logic ft, fs, ff;
        logic [5:0] ce;
        logic [3:0] cw, he, hw;
        {tf, sf, fe, n, ct, cs, x11, x10, ht, hs, p11, p10} = v;
        ft = tf & n;  fs = sf & n;  ff = ~fe & n;                       // R1 R3 R5 gated by state
        ce = {ft ? 1'b1 : ct, fs ? 1'b1 : cs, ff ? 2'b00 : x11, ff ? 2'b00 : x10};
        cw = {~ft, ~fs, ~ff, ~ff};                                       // R10
        he = {tf | ht, sf | hs, ~fe | p11, ~fe | p10};                   // R2 R4 R6
        hw = {~tf, ~sf, fe, fe};
        return {ce, cw, he, hw};
    endfunction

    task automatic check(input string tag, input logic [13:0] v);
        logic [17:0] exp_v, act;
        @(negedge clk);
        exp_v = expect_of(v);
        act   = {o_ctrc, o_csimd, o_a11, o_a10, o_cwen, o_htrc, o_hsimd, o_t11, o_t10, o_hwen};
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s: in=%b actual=%b expected=%b", tag, v, act, exp_v);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // Reset state: all controls and stored fields zero, fp disabled in Secure (R7)
        {trc_off, simd_off, fp_en, ns, ctrc, csimd, a11, a10, htrc, hsimd, t11, t10} = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        check("R7 R6 reset state", 14'b0);

        // Table walk (R1 R2 R3 R4 R5 R6 R7 R8 R10)
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i]);
            check("R1-R8 table vector", VEC[i]);
        end

        // R9: stored values survive an override and reappear once cleared
        drive(14'b1101_00_10_01_0101);
        check("R9 override active", 14'b1101_00_10_01_0101);
        drive(14'b0011_00_10_01_0101);
        check("R9 override cleared", 14'b0011_00_10_01_0101);

        // R10: write enable flips in the same cycle as the control bit
        drive(14'b0011_11_11_11_0000);
        check("R10 enables open", 14'b0011_11_11_11_0000);
        drive(14'b1111_11_11_11_0000);
        check("R10 enables closed", 14'b1111_11_11_11_0000);

        // Exhaustive sweep of every input combination (R7 R8 R10 cross-coupling)
        for (int v = 0; v < (1 << 14); v++) begin
            drive(14'(v));
            check("R7 R8 sweep", 14'(v));
        end

        finish_run();
    end

endmodule